// File: doc/BRIEF.md
# Multi-channel third-order sinc decimator for shunt-current bitstreams

This block turns several single-bit sigma-delta modulator streams into multi-bit current samples. Each stream gets its own third-order sinc filter. Typically there are three phase-current streams and one DC-bus stream. All streams are sampled on the same clock edges, which is the shared modulator clock. A single decimation phase counter decides when every channel's comb section runs. The phase currents and the bus current are therefore always taken for the same instant.

The controller selects the decimation ratio with a 2-bit code. A PWM-synchronous pulse moves the decimation phase so that captures fall on the instant the modulation pattern calls for. Samples from all channels appear together, and a one-cycle valid pulse marks them. The block also reports the filter group delay for the selected ratio, counted in modulator clocks, so the firmware can line current feedback up with its PWM edges. After reset, after a ratio change or after a sync that moves the phase, the first three decimated results are held back because the filter history is not yet consistent.

Top module: `sinc3_decimator`

## Requirements
- R1: A bit value of 1 counts as +1 and 0 as -1. Each released sample of a channel is the sum over k = 0 .. 3R-3 of w[k]·x(e-3-k). Here e is the clock edge at which the sample appears, x(n) is the bit sampled at edge n, and w is the impulse response of three cascaded length-R moving sums. The result is two's complement, sign-extended into a 25-bit field.
- R2: The ratio code on `osrSel` selects R: code 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256.
- R3: The decimation phase runs freely. A capture happens on the R-th clock edge after the phase restarts and then on every R-th edge. Outside capture edges `sampleValid` stays low.
- R4: All channels are captured on the same edge. Channel c sits in bits [25·c+24 : 25·c] of `sampleOut`.
- R5: A `pwmSync` pulse restarts the phase unless it arrives on an edge that already ends a period; a pulse on such an edge changes nothing. After a restarting pulse at edge s, the next capture is at edge s+R and no capture happens at edge s.
- R6: After reset, after any ratio-code change and after a phase-restarting sync, the first three captures keep `sampleValid` low. The fourth and later captures raise it.
- R7: `latency` equals 3R/2-1 (47, 95, 191, 383). It follows a new ratio code one clock edge after the code changes.
- R8: `sampleValid` lasts one cycle. `sampleOut` changes only on capture edges.
- R9: A window of all ones gives R³-1, the largest value that fits in 3·log2(R)+1 signed bits. A window of all zeros gives -R³.
- R10: During reset `sampleOut` is zero, `sampleValid` is low and `latency` reads 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared modulator clock; each rising edge samples every stream |
| rstN | input | 1 | Asynchronous active-low reset |
| osrSel | input | 2 | Decimation ratio code |
| pwmSync | input | 1 | PWM-aligned phase restart pulse |
| bitIn | input | NUM_CH | One modulator bit per channel |
| sampleOut | output | NUM_CH·25 | Packed signed samples, channel 0 in the low field |
| sampleValid | output | 1 | One-cycle pulse marking settled samples |
| latency | output | 9 | Filter group delay in modulator clocks |

## Verification
The bench goes after the exact capture edge and the exact data window. A comb fed from the wrong integrator tap, or a counter off by one, shows up as data shifted by a bit period or as a valid pulse one edge early or late. Syncs are applied both on and off a period boundary: a design that restarts on every sync would drop a capture on an aligned pulse, and one that ignores sync would keep its old phase. Ratio changes check the settle count, where releasing the third capture would expose history taken at the old spacing. Constant windows at 32 and 256 probe the positive full-scale limit, where a design without the extra accumulator bit or without the limit would wrap to the most negative value.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int SEL_W     = 2;
  localparam int BASE_LOG2 = 5;
  localparam int MAX_LOG2  = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int OUT_W     = 3 * MAX_LOG2 + 1;
  localparam int ACC_W     = OUT_W + 1;
  localparam int LAT_W     = $clog2(3 << (MAX_LOG2 - 1));

  typedef struct packed {
    logic             capture;
    logic             publish;
    logic [SEL_W-1:0] ratioSel;
  } decStrobe_t;
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] osrSel,
  input  logic             pwmSync,
  output decStrobe_t       strobe,
  output logic [LAT_W-1:0] latency
);
  localparam int CNT_W = MAX_LOG2;

  logic [SEL_W-1:0] selQ;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastCnt;
  logic [1:0]       settleCnt;
  logic             selChange;
  logic             atEnd;
  logic             restart;
  logic             capture;

  always_comb begin
    lastCnt   = CNT_W'((1 << (BASE_LOG2 + int'(selQ))) - 1);
    selChange = (osrSel != selQ);
    atEnd     = (phaseCnt == lastCnt);
    // an aligned sync coincides with the natural wrap and restarts nothing
    restart   = selChange || (pwmSync && !atEnd);
    capture   = atEnd && !selChange;
    latency   = LAT_W'((3 << (BASE_LOG2 + int'(selQ) - 1)) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ      <= '0;
      phaseCnt  <= '0;
      settleCnt <= '0;
    end else begin
      selQ <= osrSel;
      if (restart || atEnd) phaseCnt <= '0;
      else                  phaseCnt <= phaseCnt + CNT_W'(1);
      if (restart)                              settleCnt <= '0;
      else if (capture && settleCnt != 2'd3)    settleCnt <= settleCnt + 2'd1;
    end
  end

  always_comb begin
    strobe.capture  = capture;
    strobe.publish  = capture && (settleCnt == 2'd3);
    strobe.ratioSel = selQ;
  end
endmodule

// File: rtl/sinc3_channel.sv
module sinc3_channel
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             capture,
  input  logic [SEL_W-1:0] ratioSel,
  output logic [OUT_W-1:0] sample
);
  logic [ACC_W-1:0] xVal;
  logic [ACC_W-1:0] integ1, integ2, integ3;
  logic [ACC_W-1:0] integ3Prev, diff1Prev, diff2Prev;
  logic [ACC_W-1:0] diff1, diff2, diff3;
  logic [ACC_W-1:0] fullScale;
  logic [OUT_W-1:0] sampleNext;

  always_comb begin
    xVal       = bitIn ? ACC_W'(1) : {ACC_W{1'b1}};
    diff1      = integ3 - integ3Prev;
    diff2      = diff1 - diff1Prev;
    diff3      = diff2 - diff2Prev;
    fullScale  = ACC_W'(1) << (3 * (BASE_LOG2 + int'(ratioSel)));
    sampleNext = OUT_W'((diff3 == fullScale) ? diff3 - ACC_W'(1) : diff3);
  end

  // integrators: every modulator clock, modular arithmetic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ1 <= '0;
      integ2 <= '0;
      integ3 <= '0;
    end else begin
      integ1 <= integ1 + xVal;
      integ2 <= integ2 + integ1;
      integ3 <= integ3 + integ2;
    end
  end

  // combs: only on capture edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ3Prev <= '0;
      diff1Prev  <= '0;
      diff2Prev  <= '0;
      sample     <= '0;
    end else if (capture) begin
      integ3Prev <= integ3;
      diff1Prev  <= diff1;
      diff2Prev  <= diff2;
      sample     <= sampleNext;
    end
  end
endmodule

// File: rtl/sinc3_datapath.sv
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       bitIn,
  input  decStrobe_t              strobe,
  output logic [NUM_CH*OUT_W-1:0] sampleOut,
  output logic                    sampleValid
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    sinc3_channel u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .bitIn    (bitIn[ch]),
      .capture  (strobe.capture),
      .ratioSel (strobe.ratioSel),
      .sample   (sampleOut[ch*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleValid <= 1'b0;
    else       sampleValid <= strobe.publish;
  end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SEL_W-1:0]        osrSel,
  input  logic                    pwmSync,
  input  logic [NUM_CH-1:0]       bitIn,
  output logic [NUM_CH*OUT_W-1:0] sampleOut,
  output logic                    sampleValid,
  output logic [LAT_W-1:0]        latency
);
  decStrobe_t ctl;

  sinc3_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .osrSel  (osrSel),
    .pwmSync (pwmSync),
    .strobe  (ctl),
    .latency (latency)
  );

  sinc3_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .bitIn       (bitIn),
    .strobe      (ctl),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk
  import sinc3_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [SEL_W-1:0]        osrSel,
  input logic                    pwmSync,
  input logic [NUM_CH*OUT_W-1:0] sampleOut,
  input logic                    sampleValid,
  input logic [LAT_W-1:0]        latency,
  input logic                    ctlCapture,
  input logic                    ctlPublish
);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctlCapture |=> $stable(sampleOut));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> latency == LAT_W'((3 << (BASE_LOG2 + int'($past(osrSel)) - 1)) - 1));

  p_publish_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(ctlPublish));

  p_sync_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    pwmSync && !ctlCapture |=> !sampleValid);
endmodule

bind sinc3_decimator sinc3_decimator_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .osrSel      (osrSel),
  .pwmSync     (pwmSync),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid),
  .latency     (latency),
  .ctlCapture  (ctl.capture),
  .ctlPublish  (ctl.publish)
);

// File: tb/sim_sinc3_decimator.sv
module sim_sinc3_decimator;
  localparam int NCH = 4;
  localparam int DW  = 25;
  localparam int LW  = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rstN;
  logic [1:0]     osrSel;
  logic           pwmSync;
  logic [NCH-1:0] bitIn;
  logic [NCH*DW-1:0] sampleOut;
  logic           sampleValid;
  logic [LW-1:0]  latency;

  sinc3_decimator #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .osrSel(osrSel), .pwmSync(pwmSync), .bitIn(bitIn),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .latency(latency)
  );

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;
  int hist[NCH][1024];
  int wgt[768];
  int edgeNo;
  int mSel, mCnt, mSettle;
  string dataTag = "R1";
  logic [NCH*DW-1:0] prevOut;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void buildW(input int r);
    for (int k = 0; k < 3*r-2; k++) begin
      int s = 0;
      for (int j = 0; j < r; j++) begin
        int i = k - j;
        if (i >= 0 && i <= 2*r-2) s += ((i < 2*r-2-i) ? i : 2*r-2-i) + 1;
      end
      wgt[k] = s;
    end
  endfunction

  function automatic int xAt(input int c, input int idx);
    if (idx < 1) return 0;
    return hist[c][idx % 1024];
  endfunction

  function automatic int expSample(input int c, input int e, input int r);
    int y = 0;
    for (int k = 0; k < 3*r-2; k++) y += wgt[k] * xAt(c, e-3-k);
    if (y == r*r*r) y = r*r*r - 1;
    return y;
  endfunction

  task automatic tick(input logic [NCH-1:0] b, input logic s, input logic [1:0] sel);
    int r;
    bit cap, expV, suppressed;
    bitIn = b; pwmSync = s; osrSel = sel;
    prevOut = sampleOut;
    @(posedge clk);
    edgeNo++;
    for (int c = 0; c < NCH; c++) hist[c][edgeNo % 1024] = b[c] ? 1 : -1;
    r = 32 << mSel;
    cap = 0; expV = 0; suppressed = 0;
    if (int'(sel) != mSel) begin
      mSel = sel; mCnt = 0; mSettle = 0; buildW(32 << mSel);
    end else if (s && mCnt != r-1) begin
      mCnt = 0; mSettle = 0;
    end else begin
      cap = (mCnt == r-1);
      mCnt = cap ? 0 : mCnt + 1;
      if (cap) begin
        expV = (mSettle == 3);
        suppressed = !expV;
        if (mSettle < 3) mSettle++;
      end
    end
    @(negedge clk);
    if (suppressed) chk("R6", int'(sampleValid), 0);
    else if (cap || sampleValid) chk("R3", int'(sampleValid), int'(expV));
    if (!cap) chk("R8", int'(sampleOut == prevOut), 1);
    if (expV && sampleValid) begin
      for (int c = 0; c < NCH; c++)
        chk((c == 0) ? dataTag : "R4", int'($signed(sampleOut[c*DW +: DW])),
            expSample(c, edgeNo, 32 << mSel));
    end
  endtask

  function automatic logic [NCH-1:0] randBits(input int base);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = (($urandom % 100) < (base + 17*c) % 100);
    return v;
  endfunction

  task automatic runRandom(input int n, input int base);
    for (int i = 0; i < n; i++) tick(randBits(base), 1'b0, osrSel);
  endtask

  task automatic runConst(input int n, input logic [NCH-1:0] v);
    for (int i = 0; i < n; i++) tick(v, 1'b0, osrSel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; bitIn = '0; pwmSync = 1'b0; osrSel = 2'd0;
    edgeNo = 0; mSel = 0; mCnt = 0; mSettle = 0;
    for (int c = 0; c < NCH; c++) for (int i = 0; i < 1024; i++) hist[c][i] = 0;
    buildW(32);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", int'(sampleValid), 0);
    chk("R10", int'(sampleOut == '0), 1);
    chk("R10", int'(latency), 47);
    rstN = 1'b1;

    // R1: random streams at ratio 32
    dataTag = "R1";
    runRandom(40*32, 30);
    runRandom(20*32, 70);
    tick(4'b0101, 1'b0, 2'd0);
    for (int i = 0; i < 10*32; i++) tick((i % 2) ? 4'b1010 : 4'b0101, 1'b0, 2'd0);

    // R9: full scale at ratio 32
    dataTag = "R9";
    runConst(6*32, 4'hF);
    chk("R9", int'($signed(sampleOut[0 +: DW])), 32*32*32 - 1);
    runConst(6*32, 4'h0);
    chk("R9", int'($signed(sampleOut[DW +: DW])), -(32*32*32));

    // R5: aligned sync first, then misaligned
    dataTag = "R5";
    while (mCnt != 31) tick(randBits(50), 1'b0, 2'd0);
    tick(randBits(50), 1'b1, 2'd0);
    runRandom(6*32, 45);
    while (mCnt != 13) tick(randBits(50), 1'b0, 2'd0);
    tick(randBits(50), 1'b1, 2'd0);
    for (int i = 0; i < 31; i++) begin
      tick(randBits(50), 1'b0, 2'd0);
      chk("R5", int'(mCnt == 0), 0);
    end
    runRandom(8*32, 55);

    // R2 and R7: ratio sweep
    for (int s = 1; s < 4; s++) begin
      dataTag = "R2";
      tick(randBits(40), 1'b0, 2'(s));
      chk("R7", int'(latency), 3*(32 << s)/2 - 1);
      runRandom(7*(32 << s), 25 + 10*s);
    end

    // R9: full scale at ratio 256
    dataTag = "R9";
    runConst(5*256, 4'hF);
    chk("R9", int'($signed(sampleOut[2*DW +: DW])), 256*256*256 - 1);
    runConst(5*256, 4'h0);
    chk("R9", int'($signed(sampleOut[3*DW +: DW])), -(256*256*256));

    // back to ratio 32, R7
    tick(4'h0, 1'b0, 2'd0);
    chk("R7", int'(latency), 47);
    dataTag = "R1";
    runRandom(6*32, 60);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule